// File: doc/BRIEF.md
# Power-up reset delay sequencer

This block produces the internal reset of a small device during power-up. Its inputs are an active-high power-on-reset pulse, an active-low external reset pin and a one-cycle tick from a slow internal oscillator. Once the power-on pulse clears, a fixed-length delay counter advances on each tick. The device is held in reset until the counter expires. The counter is always enabled and has no bypass.

The external pin runs alongside the timer and does not control it. The pin is synchronized before use. Pulling it low forces the internal reset straight away. Releasing it takes effect after the synchronizer latency. The timer is started only by the end of the power-on pulse. If the pin is held low past expiry, execution begins as soon as the pin is released, with no further timer delay. A new power-on pulse restarts the whole sequence at any time.

Top module: `pwrup_seq`

## Requirements
- R1: While `por_i` is high, `core_rst_o` is 1 and `delay_done_o` is 0, and the delay counter is cleared.
- R2: `delay_done_o` rises on the clock edge that consumes the 2^CNT_W-th tick counted after `por_i` fell. After 2^CNT_W - 1 ticks it is still 0. Clock edges without a tick do not advance the count.
- R3: Ticks that arrive while `por_i` is high are not counted.
- R4: `core_rst_o` is 1 for as long as `delay_done_o` is 0.
- R5: Once the delay has expired, the counter holds its terminal value. `delay_done_o` stays 1 through any further ticks until the next power-on pulse.
- R6: A power-on pulse in the middle of the count restarts the full delay of 2^CNT_W ticks.
- R7: `ext_rst_n_i` at 0 forces `core_rst_o` to 1 in the same cycle, before any clock edge.
- R8: When the delay has expired and `ext_rst_n_i` rises, `core_rst_o` falls after the second following clock edge (SYNC_STAGES = 2). It stays 1 after the first edge.
- R9: If `ext_rst_n_i` is held low until after expiry, the release of the pin alone ends the reset, with the latency of R8 and no further timer delay.
- R10: A low pulse on `ext_rst_n_i` while the counter is running neither restarts nor extends the delay.
- R11: `core_rst_o` is 0 only when the delay has expired and the pin is high, both raw and synchronized.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| por_i | input | 1 | Power-on-reset pulse, active high, asynchronous clear |
| ext_rst_n_i | input | 1 | External reset pin, active low, asynchronous to clk_i |
| tick_i | input | 1 | One-cycle tick from the slow internal oscillator |
| core_rst_o | output | 1 | Internal reset to the device, active high |
| delay_done_o | output | 1 | The delay counter has expired |

## Verification
The bench builds the block with CNT_W = 5, so the delay is 32 ticks, and with the default two-stage synchronizer. At this width the terminal count, saturation under extra ticks and restart by a power-on pulse are each reached within a few hundred cycles. Tick spacings of one to three clocks show that only ticks advance the count. The synchronizer latency is checked edge by edge after expiry.

// File: rtl/pwrup_seq_pkg.sv
package pwrup_seq_pkg;

  // Highest count value of a w-bit delay counter.
  function automatic int unsigned last_count(input int unsigned w);
    return (32'd1 << w) - 32'd1;
  endfunction

  // Number of ticks in the full delay.
  function automatic int unsigned delay_ticks(input int unsigned w);
    return 32'd1 << w;
  endfunction

  // The core may run only with the timer expired and the pin high, raw and synced.
  function automatic logic core_may_run(input logic expired,
                                        input logic pin_raw_n,
                                        input logic pin_sync_n);
    return expired & pin_raw_n & pin_sync_n;
  endfunction

endpackage

// File: rtl/pwrup_pin_sync.sv
module pwrup_pin_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic por_i,
  input  logic pin_n_i,
  output logic pin_n_o
);
  localparam int unsigned N = (STAGES < 2) ? 2 : STAGES;

  logic [N-1:0] stage_q;

  // Resets to the asserted (low) level so that release always has full latency.
  always_ff @(posedge clk_i or posedge por_i) begin
    if (por_i) stage_q <= '0;
    else       stage_q <= {stage_q[N-2:0], pin_n_i};
  end

  assign pin_n_o = stage_q[N-1];

  // R8: a rise at the output was present one stage earlier on the edge before
  p_sync_order_r8: assert property (@(posedge clk_i) disable iff (por_i)
    $rose(pin_n_o) |-> $past(stage_q[N-2]));
endmodule

// File: rtl/pwrup_delay_cnt.sv
module pwrup_delay_cnt
  import pwrup_seq_pkg::*;
#(
  parameter int unsigned CNT_W = 11
) (
  input  logic             clk_i,
  input  logic             por_i,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             done_o
);
  localparam logic [CNT_W-1:0] TERM = CNT_W'(last_count(CNT_W));

  logic [CNT_W-1:0] cnt_q;
  logic             done_q;
  logic             step;
  logic             final_step;

  assign step       = tick_i & ~done_q;
  assign final_step = step & (cnt_q == TERM);

  always_ff @(posedge clk_i or posedge por_i) begin
    if (por_i) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (final_step) begin
      done_q <= 1'b1;
    end else if (step) begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign cnt_o  = cnt_q;
  assign done_o = done_q;

  // R5: once expired, the flag and the saturated count stay put
  p_done_sticky_r5: assert property (@(posedge clk_i) disable iff (por_i)
    done_q |=> (done_q && cnt_q == TERM));
  // R2: expiry happens only on a tick taken at the terminal count
  p_done_on_last_tick_r2: assert property (@(posedge clk_i) disable iff (por_i)
    $rose(done_q) |-> ($past(tick_i) && $past(cnt_q) == TERM));
  // R2: no tick, no movement
  p_no_tick_no_step_r2: assert property (@(posedge clk_i) disable iff (por_i)
    !tick_i |=> $stable(cnt_q));
endmodule

// File: rtl/pwrup_seq.sv
module pwrup_seq
  import pwrup_seq_pkg::*;
#(
  parameter int unsigned CNT_W       = 11,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic por_i,
  input  logic ext_rst_n_i,
  input  logic tick_i,
  output logic core_rst_o,
  output logic delay_done_o
);
  logic [CNT_W-1:0] count;
  logic             expired;
  logic             pin_sync_n;
  logic             run_ok;

  pwrup_delay_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .por_i  (por_i),
    .tick_i (tick_i),
    .cnt_o  (count),
    .done_o (expired)
  );

  pwrup_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .por_i   (por_i),
    .pin_n_i (ext_rst_n_i),
    .pin_n_o (pin_sync_n)
  );

  assign run_ok       = core_may_run(expired, ext_rst_n_i, pin_sync_n);
  assign core_rst_o   = por_i | ~run_ok;
  assign delay_done_o = expired;

  // R4: held in reset while the counter is running
  p_rst_while_counting_r4: assert property (@(posedge clk_i) disable iff (por_i)
    !expired |-> core_rst_o);
  // R11: leaving reset needs the timer expired and the synced pin high
  p_release_needs_both_r11: assert property (@(posedge clk_i) disable iff (por_i)
    !core_rst_o |-> (expired && pin_sync_n && count == CNT_W'(last_count(CNT_W))));
  // R7: a low pin is seen at the output without waiting for the synchronizer
  p_pin_forces_rst_r7: assert property (@(posedge clk_i) disable iff (por_i)
    (!ext_rst_n_i && pin_sync_n) |-> core_rst_o);
endmodule

// File: tb/pwrup_seq_tb.sv
module pwrup_seq_tb;
  localparam int unsigned W     = 5;
  localparam int unsigned TICKS = 32;

  logic clk = 1'b0;
  logic por = 1'b1;
  logic ext_n = 1'b1;
  logic tick = 1'b0;
  logic core_rst, done;

  int checks = 0;
  int errors = 0;
  bit ended  = 1'b0;

  always #5 clk = ~clk;

  pwrup_seq #(.CNT_W(W), .SYNC_STAGES(2)) u_dut (
    .clk_i        (clk),
    .por_i        (por),
    .ext_rst_n_i  (ext_n),
    .tick_i       (tick),
    .core_rst_o   (core_rst),
    .delay_done_o (done)
  );

  // Rows: [5:3] extra ticks after expiry, [2] pin held low, [1:0] tick gap
  localparam logic [5:0] VEC [0:3] = '{
    6'b000_0_01,
    6'b010_1_10,
    6'b011_0_11,
    6'b001_1_01
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic ticks(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
      repeat (gap - 1) @(negedge clk);
    end
  endtask

  task automatic restart();
    @(negedge clk) por = 1'b1;
    @(negedge clk);
    chk(core_rst == 1'b1, "R1 rst during por", core_rst, 1);
    chk(done == 1'b0, "R1 done during por", done, 0);
    por = 1'b0;
  endtask

  // Pin release after expiry: two edges of latency
  task automatic release_pin(input string req);
    @(negedge clk) ext_n = 1'b1;
    #1 chk(core_rst == 1'b1, req, core_rst, 1);
    @(negedge clk);
    chk(core_rst == 1'b1, req, core_rst, 1);
    @(negedge clk);
    chk(core_rst == 1'b0, req, core_rst, 0);
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(core_rst == 1'b1, "R1 rst at start", core_rst, 1);
    chk(done == 1'b0, "R1 done at start", done, 0);

    // Table walk: R2, R4, R5, R9, R11
    for (int r = 0; r < 4; r++) begin
      int gap;
      int extra;
      bit low;
      gap   = int'(VEC[r][1:0]);
      low   = VEC[r][2];
      extra = int'(VEC[r][5:3]);
      @(negedge clk) ext_n = ~low;
      restart();
      ticks(TICKS - 1, gap);
      chk(done == 1'b0, "R2 one tick short", done, 0);
      chk(core_rst == 1'b1, "R4 rst while counting", core_rst, 1);
      ticks(1, gap);
      chk(done == 1'b1, "R2 done on last tick", done, 1);
      chk(core_rst == low, "R11 rst after expiry", core_rst, low);
      ticks(extra, gap);
      chk(done == 1'b1, "R5 done holds", done, 1);
      if (low) release_pin("R9 release after expiry");
    end

    // R3: ticks during por are ignored
    @(negedge clk) por = 1'b1;
    ticks(5, 1);
    chk(done == 1'b0, "R3 done during por", done, 0);
    @(negedge clk) por = 1'b0;
    ticks(TICKS - 1, 1);
    chk(done == 1'b0, "R3 por ticks not counted", done, 0);
    ticks(1, 1);
    chk(done == 1'b1, "R3 full delay after por", done, 1);

    // R7 and R8: pin assertion is immediate, release takes two edges
    repeat (3) @(negedge clk);
    chk(core_rst == 1'b0, "R11 running", core_rst, 0);
    @(negedge clk) ext_n = 1'b0;
    #1 chk(core_rst == 1'b1, "R7 pin forces rst", core_rst, 1);
    @(negedge clk);
    release_pin("R8 sync latency");

    // R6: por in mid-count restarts the full delay
    restart();
    ticks(10, 1);
    restart();
    ticks(TICKS - 1, 2);
    chk(done == 1'b0, "R6 restarted count short", done, 0);
    ticks(1, 1);
    chk(done == 1'b1, "R6 restarted count done", done, 1);

    // R10: a pin pulse while counting does not extend the delay
    restart();
    ticks(5, 1);
    @(negedge clk) ext_n = 1'b0;
    repeat (3) @(negedge clk);
    ext_n = 1'b1;
    ticks(TICKS - 6, 1);
    chk(done == 1'b0, "R10 still counting", done, 0);
    ticks(1, 1);
    chk(done == 1'b1, "R10 expiry not delayed", done, 1);
    chk(core_rst == 1'b0, "R10 released at expiry", core_rst, 0);

    finish_run();
  end
endmodule